// File: doc/BRIEF.md
# Byte-Lane Host Register Window

This block is the host-facing register window of a peripheral card that sits on a 16-bit processor bus whose data path reaches the card one byte at a time. Four single-byte registers occupy the odd byte of four consecutive words. The two lower registers return bytes supplied by an attached companion computer. The two upper registers capture bytes written by the host and present them to the companion side. The companion link is outside this block, so both directions appear as plain parallel ports. A separate bit-addressed control space, selected by a configurable base address, holds two bits. One bit switches the card's memory decoding on. The other drives a reset line toward the companion computer.

All bus inputs are brought into one fast internal clock. Some hosts hold memory-enable and write-enable low for both byte transfers of a word and toggle only the lowest address bit between them. For this reason a write is not tied to a strobe edge. Instead, each stable address seen while writing is one byte phase, and that phase commits at most once. Both byte orders of a word access (odd then even, or even then odd) leave exactly the odd-byte register written, and the even byte is dropped.

Top module: `bytebus_regif`

## Requirements
- R1: After a synchronous active-low reset, `bus_data_oe` is 0, both host-written bytes are 0x00, `companion_rst` is 0 and memory decoding is off.
- R2: A pulse on `ctl_wr` writes `ctl_bit` into control bit n when `ctl_addr` equals `CTL_BASE + 2*n`: n=0 is card enable and n=1 is companion reset. The new value applies from the next clock edge, and strobes at any other address change nothing.
- R3: `companion_rst` equals control bit 1 and is cleared by reset.
- R4: While card enable is 0, host writes leave both host-written bytes unchanged and `bus_data_oe` stays 0.
- R5: A host write (memory-enable and write-enable both low) to byte address `WIN_BASE+5` (0x5FFD by default) loads `bus_data_in` into host byte 0 (`host_wr_bytes[7:0]`). A write to `WIN_BASE+7` (0x5FFF) loads host byte 1 (`host_wr_bytes[15:8]`).
- R6: Writes to the even byte addresses `WIN_BASE+4` and `WIN_BASE+6` are discarded. A word access in either byte order therefore changes only the odd-byte register.
- R7: One byte phase, meaning an unchanged address under active strobes, commits at most once. A change of `bus_data_in` without an address change does not overwrite the committed byte.
- R8: `bus_data_oe` is 1 only when memory-enable is low, write-enable is high, card enable is 1, and the address is `WIN_BASE+1` (0x5FF9) or `WIN_BASE+3` (0x5FFB). `bus_data_out` then carries companion byte 0 (`comp_rd_bytes[7:0]`) or byte 1 (`comp_rd_bytes[15:8]`). Even addresses and the write addresses never enable the output.
- R9: A host write becomes visible on `host_wr_bytes` by the fourth rising edge after the bus inputs settle. A read becomes visible on the data outputs by the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Host byte address (asynchronous) |
| bus_mem_n | input | 1 | Host memory enable, active low (asynchronous) |
| bus_we_n | input | 1 | Host write enable, active low (asynchronous) |
| bus_data_in | input | 8 | Host byte lane, write direction |
| bus_data_out | output | 8 | Byte driven toward the host during reads |
| bus_data_oe | output | 1 | Output enable for the host byte lane; 0 means high impedance |
| ctl_addr | input | 16 | Control-space bit address, synchronous to clk |
| ctl_bit | input | 1 | Value written to the addressed control bit |
| ctl_wr | input | 1 | One-cycle control write strobe |
| comp_rd_bytes | input | 16 | Companion bytes the host reads, byte i at [8i+7:8i] |
| host_wr_bytes | output | 16 | Bytes written by the host, byte i at [8i+7:8i] |
| companion_rst | output | 1 | Reset line toward the companion computer |

## Verification
The host bus passes through a two-stage synchronizer and then a one-cycle stability check. A write therefore reaches `host_wr_bytes` on the fourth edge after the bus changes, and a read reaches `bus_data_oe`/`bus_data_out` on the third. Control-bit writes appear one edge after the strobe. The bench changes inputs on falling edges and holds every bus phase for six cycles. It compares results only at the falling edge that ends a phase, so each comparison lies at least two edges after the latest edge at which the result may legally arrive. Control results are compared at the first falling edge after the strobe's edge.

// File: rtl/bytebus_pkg.sv
// Shared constants and address helpers for the byte-lane register window.
// Assumes registers occupy the odd byte of consecutive 16-bit words.
package bytebus_pkg;
    // Control-space bit indices
    localparam int unsigned CTL_EN_IDX  = 0;
    localparam int unsigned CTL_RST_IDX = 1;
    localparam int unsigned NUM_CTL     = 2;

    // Odd byte address of word slot k above the window base
    function automatic logic [15:0] slot_addr(input logic [15:0] base, input int unsigned k);
        return base + 16'(2 * k + 1);
    endfunction
endpackage

// File: rtl/bytebus_sync.sv
// Multi-stage synchronizer for asynchronous bus inputs.
// Assumes the sampled group settles together; skew is absorbed by the
// stability check downstream.
module bytebus_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bytebus_ctl.sv
// Bit-addressed control space: bit n lives at CTL_BASE + 2n.
// Assumes control writes are already synchronous to clk.
module bytebus_ctl
    import bytebus_pkg::*;
#(
    parameter int unsigned  ADDR_W   = 16,
    parameter logic [15:0]  CTL_BASE = 16'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic              ctl_bit,
    input  logic              ctl_wr,
    output logic              card_en,
    output logic              comp_rst
);
    logic [NUM_CTL-1:0] bits_q;

    for (genvar n = 0; n < NUM_CTL; n++) begin : g_bit
        localparam logic [ADDR_W-1:0] BIT_ADDR = ADDR_W'(CTL_BASE + 16'(2 * n));
        // Capture the addressed bit on a control write strobe
        always_ff @(posedge clk) begin
            if (!rst_n)                               bits_q[n] <= 1'b0;
            else if (ctl_wr && ctl_addr == BIT_ADDR)  bits_q[n] <= ctl_bit;
        end
    end

    assign card_en  = bits_q[CTL_EN_IDX];
    assign comp_rst = bits_q[CTL_RST_IDX];
endmodule

// File: rtl/bytebus_wr.sv
// Host write path: detects byte phases inside long strobes by watching the
// synchronized address, commits each phase at most once, odd slots only.
// Assumes address, strobes and data share the same synchronizer latency.
module bytebus_wr
    import bytebus_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_RD   = 2,
    parameter int unsigned NUM_WR   = 2,
    parameter logic [15:0] WIN_BASE = 16'h5FF8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        s_addr,
    input  logic                     s_mem_n,
    input  logic                     s_we_n,
    input  logic [DATA_W-1:0]        s_data,
    input  logic                     card_en,
    output logic [NUM_WR-1:0]        commit,
    output logic [NUM_WR*DATA_W-1:0] wr_bytes
);
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    logic              wr_act, addr_stable;
    logic [NUM_WR-1:0] hit;

    assign wr_act      = !s_mem_n && !s_we_n && card_en;
    assign addr_stable = (s_addr == addr_q);

    // Delay the synchronized address one cycle for the stability check
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= s_addr;
    end

    // Mark the current byte phase as committed; clear on any address change
    always_ff @(posedge clk) begin
        if (!rst_n)                      done_q <= 1'b0;
        else if (!wr_act || !addr_stable) done_q <= 1'b0;
        else if (|commit)                done_q <= 1'b1;
    end

    for (genvar i = 0; i < NUM_WR; i++) begin : g_lane
        localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(slot_addr(WIN_BASE, NUM_RD + i));
        assign hit[i]    = (s_addr == LANE_ADDR);
        assign commit[i] = wr_act && addr_stable && !done_q && hit[i];

        // Load the lane register on its commit
        always_ff @(posedge clk) begin
            if (!rst_n)         wr_bytes[i*DATA_W +: DATA_W] <= '0;
            else if (commit[i]) wr_bytes[i*DATA_W +: DATA_W] <= s_data;
        end
    end
endmodule

// File: rtl/bytebus_rd.sv
// Host read path: registered output enable and byte mux for the read slots.
// Assumes companion bytes are stable over a host read.
module bytebus_rd
    import bytebus_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_RD   = 2,
    parameter logic [15:0] WIN_BASE = 16'h5FF8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        s_addr,
    input  logic                     s_mem_n,
    input  logic                     s_we_n,
    input  logic                     card_en,
    input  logic [NUM_RD*DATA_W-1:0] rd_bytes,
    output logic [DATA_W-1:0]        dout,
    output logic                     oe
);
    logic [NUM_RD-1:0] hit;
    logic [DATA_W-1:0] sel;

    for (genvar i = 0; i < NUM_RD; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(slot_addr(WIN_BASE, i));
        assign hit[i] = (s_addr == SLOT_ADDR);
    end

    // Select the byte of the matching read slot
    always_comb begin
        sel = '0;
        for (int i = 0; i < int'(NUM_RD); i++)
            if (hit[i]) sel = rd_bytes[i*DATA_W +: DATA_W];
    end

    // Register enable and data toward the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe   <= 1'b0;
            dout <= '0;
        end else begin
            oe   <= !s_mem_n && s_we_n && card_en && (|hit);
            dout <= sel;
        end
    end
endmodule

// File: rtl/bytebus_regif.sv
// Top of the byte-lane host register window: synchronizes the host bus,
// runs the read and write paths and the bit-addressed control space.
// Assumes one clk much faster than the host byte phases.
module bytebus_regif
    import bytebus_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned NUM_RD      = 2,
    parameter int unsigned NUM_WR      = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [15:0] WIN_BASE    = 16'h5FF8,
    parameter logic [15:0] CTL_BASE    = 16'h1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_mem_n,
    input  logic                     bus_we_n,
    input  logic [DATA_W-1:0]        bus_data_in,
    output logic [DATA_W-1:0]        bus_data_out,
    output logic                     bus_data_oe,
    input  logic [ADDR_W-1:0]        ctl_addr,
    input  logic                     ctl_bit,
    input  logic                     ctl_wr,
    input  logic [NUM_RD*DATA_W-1:0] comp_rd_bytes,
    output logic [NUM_WR*DATA_W-1:0] host_wr_bytes,
    output logic                     companion_rst
);
    localparam int unsigned SW = ADDR_W + DATA_W + 2;

    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_data;
    logic              s_mem_n, s_we_n;
    logic              card_en;
    logic [NUM_WR-1:0] commit;

    bytebus_sync #(
        .W(SW), .STAGES(SYNC_STAGES), .RST_VAL({{(ADDR_W+DATA_W){1'b0}}, 2'b11})
    ) sync_i (
        .clk(clk), .rst_n(rst_n),
        .d({bus_addr, bus_data_in, bus_mem_n, bus_we_n}),
        .q({s_addr, s_data, s_mem_n, s_we_n})
    );

    bytebus_ctl #(.ADDR_W(ADDR_W), .CTL_BASE(CTL_BASE)) ctl_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_addr(ctl_addr), .ctl_bit(ctl_bit), .ctl_wr(ctl_wr),
        .card_en(card_en), .comp_rst(companion_rst)
    );

    bytebus_wr #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RD(NUM_RD), .NUM_WR(NUM_WR), .WIN_BASE(WIN_BASE)
    ) wr_i (
        .clk(clk), .rst_n(rst_n),
        .s_addr(s_addr), .s_mem_n(s_mem_n), .s_we_n(s_we_n), .s_data(s_data),
        .card_en(card_en), .commit(commit), .wr_bytes(host_wr_bytes)
    );

    bytebus_rd #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RD(NUM_RD), .WIN_BASE(WIN_BASE)
    ) rd_i (
        .clk(clk), .rst_n(rst_n),
        .s_addr(s_addr), .s_mem_n(s_mem_n), .s_we_n(s_we_n),
        .card_en(card_en), .rd_bytes(comp_rd_bytes),
        .dout(bus_data_out), .oe(bus_data_oe)
    );
endmodule

// File: rtl/bytebus_regif_chk.sv
// Protocol checker for the byte-lane register window, bound into the top.
module bytebus_regif_chk #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_WR   = 2,
    parameter logic [15:0] CTL_BASE = 16'h1000
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     card_en,
    input logic [NUM_WR-1:0]        commit,
    input logic [ADDR_W-1:0]        s_addr,
    input logic                     s_mem_n,
    input logic                     s_we_n,
    input logic                     bus_data_oe,
    input logic [NUM_WR*DATA_W-1:0] host_wr_bytes,
    input logic [ADDR_W-1:0]        ctl_addr,
    input logic                     ctl_bit,
    input logic                     ctl_wr,
    input logic                     companion_rst
);
    AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !card_en |=> $stable(host_wr_bytes)); // R4

    AST_OE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> $past(card_en)); // R4

    AST_ONE_COMMIT_PER_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (|commit) |=> !(|commit)); // R7

    AST_COMMIT_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit)); // R5

    AST_COMMIT_ODD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (|commit) |-> s_addr[0]); // R6

    AST_OE_READ_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> ($past(s_we_n) && !$past(s_mem_n))); // R8

    AST_RST_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_addr == ADDR_W'(CTL_BASE + 16'd2)) |=> (companion_rst == $past(ctl_bit))); // R3
endmodule

bind bytebus_regif bytebus_regif_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WR(NUM_WR), .CTL_BASE(CTL_BASE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .card_en(card_en), .commit(commit),
    .s_addr(s_addr), .s_mem_n(s_mem_n), .s_we_n(s_we_n),
    .bus_data_oe(bus_data_oe), .host_wr_bytes(host_wr_bytes),
    .ctl_addr(ctl_addr), .ctl_bit(ctl_bit), .ctl_wr(ctl_wr),
    .companion_rst(companion_rst)
);

// File: tb/bytebus_regif_tb.sv
// Directed bench for the byte-lane register window; the card is placed at
// control base 0x1400 to exercise a non-default base.
module bytebus_regif_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 6;
    localparam logic [15:0] CBASE = 16'h1400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_mem_n = 1'b1;
    logic        bus_we_n = 1'b1;
    logic [7:0]  bus_data_in = 8'h00;
    logic [7:0]  bus_data_out;
    logic        bus_data_oe;
    logic [15:0] ctl_addr = 16'h0000;
    logic        ctl_bit = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] comp_rd_bytes = 16'hC35A;
    logic [15:0] host_wr_bytes;
    logic        companion_rst;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytebus_regif #(.CTL_BASE(CBASE)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_mem_n(bus_mem_n), .bus_we_n(bus_we_n),
        .bus_data_in(bus_data_in), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
        .ctl_addr(ctl_addr), .ctl_bit(ctl_bit), .ctl_wr(ctl_wr),
        .comp_rd_bytes(comp_rd_bytes), .host_wr_bytes(host_wr_bytes),
        .companion_rst(companion_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive one bus phase and hold it
    task automatic phase(input logic [15:0] a, input logic mem_n, input logic we_n, input logic [7:0] d);
        bus_addr = a; bus_mem_n = mem_n; bus_we_n = we_n; bus_data_in = d;
        wait_cyc(HOLD);
    endtask

    task automatic idle();
        phase(16'h0000, 1'b1, 1'b1, 8'h00);
    endtask

    task automatic ctl_write(input logic [15:0] a, input logic v);
        ctl_addr = a; ctl_bit = v; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic t_reset();
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe", bus_data_oe, 0);
        check("R1 host bytes", host_wr_bytes, 0);
        check("R1 companion_rst", companion_rst, 0);
    endtask

    task automatic t_disabled();
        phase(16'h5FFD, 1'b0, 1'b0, 8'h99);
        idle();
        check("R4 write ignored while disabled", host_wr_bytes, 0);
        phase(16'h5FF9, 1'b0, 1'b1, 8'h00);
        check("R4 read oe while disabled", bus_data_oe, 0);
        idle();
    endtask

    task automatic t_ctl_bits();
        ctl_write(16'h1002, 1'b1);
        check("R2 other base ignored", companion_rst, 0);
        ctl_write(CBASE + 16'd2, 1'b1);
        check("R3 reset asserted", companion_rst, 1);
        ctl_write(CBASE + 16'd2, 1'b0);
        check("R3 reset released", companion_rst, 0);
        ctl_write(16'h1000, 1'b1);
        phase(16'h5FF9, 1'b0, 1'b1, 8'h00);
        check("R2 enable at wrong base ignored", bus_data_oe, 0);
        idle();
        ctl_write(CBASE, 1'b1);
    endtask

    task automatic t_word_odd_first();
        bus_mem_n = 1'b0; bus_we_n = 1'b0;
        phase(16'h5FFD, 1'b0, 1'b0, 8'hA5);
        check("R9 write latency", host_wr_bytes, 16'h00A5);
        phase(16'h5FFC, 1'b0, 1'b0, 8'h3C);
        idle();
        check("R6 odd-first word keeps odd byte", host_wr_bytes, 16'h00A5);
    endtask

    task automatic t_word_even_first();
        phase(16'h5FFE, 1'b0, 1'b0, 8'h11);
        phase(16'h5FFF, 1'b0, 1'b0, 8'h77);
        idle();
        check("R6 even-first word keeps odd byte", host_wr_bytes, 16'h77A5);
    endtask

    task automatic t_byte_write();
        phase(16'h5FFD, 1'b0, 1'b0, 8'h0F);
        idle();
        check("R5 byte 0 write", host_wr_bytes, 16'h770F);
    endtask

    task automatic t_one_commit();
        phase(16'h5FFF, 1'b0, 1'b0, 8'h21);
        phase(16'h5FFF, 1'b0, 1'b0, 8'h43);
        idle();
        check("R7 single commit per phase", host_wr_bytes, 16'h210F);
    endtask

    task automatic t_reads();
        phase(16'h5FF9, 1'b0, 1'b1, 8'h00);
        check("R8 oe slot 0", bus_data_oe, 1);
        check("R8 data slot 0", bus_data_out, 8'h5A);
        phase(16'h5FFB, 1'b0, 1'b1, 8'h00);
        check("R8 data slot 1", bus_data_out, 8'hC3);
        phase(16'h5FF8, 1'b0, 1'b1, 8'h00);
        check("R8 even address no drive", bus_data_oe, 0);
        phase(16'h5FFD, 1'b0, 1'b1, 8'h00);
        check("R8 write address no drive", bus_data_oe, 0);
        phase(16'h5FF9, 1'b1, 1'b1, 8'h00);
        check("R8 no memory enable no drive", bus_data_oe, 0);
        bus_addr = 16'h5FFB; bus_mem_n = 1'b0;
        wait_cyc(3);
        check("R9 read latency", bus_data_oe, 1);
        idle();
    endtask

    task automatic t_disable_again();
        ctl_write(CBASE, 1'b0);
        phase(16'h5FFD, 1'b0, 1'b0, 8'hEE);
        idle();
        check("R4 write ignored after disable", host_wr_bytes, 16'h210F);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_ctl_bits();
        t_word_odd_first();
        t_word_even_first();
        t_byte_write();
        t_one_commit();
        t_reads();
        t_disable_again();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule